// File: doc/BRIEF.md
# I2C Two-Factor Baud Rate Generator

This block makes the timing ticks for an I2C master from a fast system clock. A 7-bit clock configuration word carries two factors. The first is a power-of-two exponent N that sets a prescaler. The second is a linear factor M that sets how many prescaled periods make one tick. Each tick marks one tenth of an SCL period. A second output fires once for every ten ticks and marks the full SCL period.

The SCL rate is the system clock divided by 10 × (M+1) × 2^(N+1). A mode input removes the extra factor of two, so the divisor becomes 10 × (M+1) × 2^N. Writing a new configuration word restarts the counters, and so does a change of the mode input. The first tick after a restart therefore follows the new ratio in full. A bus-protocol engine uses both outputs to pace its SCL and SDA edges. Choosing good values for M and N is left to software.

Top module: `i2c_baud_gen`

## Requirements
- R1: The configuration word is 7 bits wide. Bits 2:0 hold N (0 to 7) and bits 6:3 hold M (0 to 15). It is loaded on a clock edge where `cfgWrEn` is high.
- R2: With `altExp` low, `tickOut` pulses once every (M+1) × 2^(N+1) clock cycles.
- R3: With `altExp` high, `tickOut` pulses once every (M+1) × 2^N clock cycles. With M=0 and N=0 it is high on every cycle.
- R4: Each `tickOut` pulse lasts one cycle whenever the tick period is longer than one cycle.
- R5: A configuration write restarts all counting. `tickOut` is low in the cycle after the write edge, and the first tick comes exactly one new period after that edge.
- R6: A change of `altExp` restarts all counting in the same way as a write, using the stored M and N.
- R7: `sclStrobe` pulses on every tenth tick counted from a restart, in the same cycle as that tick, so its period is ten tick periods.
- R8: Reset clears the configuration to M=0 and N=0 and holds both outputs low. After reset is released with `altExp` low, ticks follow a period of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Load strobe for the configuration word |
| cfgWrData | input | 7 | Configuration word: M in bits 6:3, N in bits 2:0 |
| altExp | input | 1 | 0: prescale by 2^(N+1); 1: prescale by 2^N |
| tickOut | output | 1 | One-cycle pulse per tenth of an SCL period |
| sclStrobe | output | 1 | One-cycle pulse per SCL period |

## Verification
Let D be the tick period for the active configuration and mode. After a write or mode-change edge, `tickOut` is due at exactly D, 2D, 3D and so on edges later. `sclStrobe` is due at every multiple of 10D edges. The bench counts edges from each restart edge, reads both outputs at the following falling edge, and compares every cycle of a window with this formula. The window always covers the restart cycle, where both outputs must be low. Reset release is handled the same way: the first rising edge after release counts as edge one.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int M_W   = 4;            // width of the linear factor
  localparam int N_W   = 3;            // width of the exponent
  localparam int CFG_W = M_W + N_W;    // configuration word width
  localparam int PRE_W = 1 << N_W;     // prescaler counter width (max 2^(2^N_W))

  typedef struct packed {
    logic             restart;         // clear every counter this edge
    logic [PRE_W-1:0] preLast;         // terminal value of the prescaler
    logic [M_W-1:0]   mLast;           // terminal value of the M counter
  } baudCtrl_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             altExp,
  output logic [CFG_W-1:0] cfgQ,
  output baudCtrl_t        ctrl
);
  localparam int SH_W = N_W + 1;

  logic             modeQ;
  logic [N_W-1:0]   nField;
  logic [M_W-1:0]   mField;
  logic [SH_W-1:0]  shiftAmt;
  logic [PRE_W:0]   span;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      modeQ <= 1'b0;
    end else begin
      modeQ <= altExp;
      if (cfgWrEn) cfgQ <= cfgWrData;
    end
  end

  // Field decode: exponent in the low bits, linear factor above it
  assign nField = cfgQ[N_W-1:0];
  assign mField = cfgQ[CFG_W-1:N_W];

  always_comb begin
    shiftAmt     = {1'b0, nField} + (altExp ? SH_W'(0) : SH_W'(1));
    span         = (PRE_W+1)'(1) << shiftAmt;
    ctrl.restart = cfgWrEn || (altExp != modeQ);
    ctrl.preLast = PRE_W'(span - (PRE_W+1)'(1));
    ctrl.mLast   = mField;
  end
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int TENTHS = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  baudCtrl_t ctrl,
  output logic      tickOut,
  output logic      sclStrobe
);
  localparam int TEN_W = (TENTHS > 1) ? $clog2(TENTHS) : 1;

  logic [PRE_W-1:0] preCnt;
  logic [M_W-1:0]   mCnt;
  logic [TEN_W-1:0] tenCnt;
  logic             preWrap;
  logic             tickNow;
  logic             sclNow;

  assign preWrap = (preCnt == ctrl.preLast);
  assign tickNow = preWrap && (mCnt == ctrl.mLast);
  assign sclNow  = tickNow && (tenCnt == TEN_W'(TENTHS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      mCnt      <= '0;
      tenCnt    <= '0;
      tickOut   <= 1'b0;
      sclStrobe <= 1'b0;
    end else if (ctrl.restart) begin
      preCnt    <= '0;
      mCnt      <= '0;
      tenCnt    <= '0;
      tickOut   <= 1'b0;
      sclStrobe <= 1'b0;
    end else begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (preWrap) mCnt   <= (mCnt == ctrl.mLast) ? '0 : mCnt + 1'b1;
      if (tickNow) tenCnt <= sclNow ? '0 : tenCnt + 1'b1;
      tickOut   <= tickNow;
      sclStrobe <= sclNow;
    end
  end
endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen
  import baud_pkg::*;
#(
  parameter int TENTHS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             altExp,
  output logic             tickOut,
  output logic             sclStrobe
);
  baudCtrl_t        ctrl;
  logic [CFG_W-1:0] cfgQ;

  baud_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .altExp(altExp), .cfgQ(cfgQ), .ctrl(ctrl)
  );

  baud_datapath #(.TENTHS(TENTHS)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .tickOut(tickOut), .sclStrobe(sclStrobe)
  );
endmodule

// File: rtl/baud_checker.sv
module baud_checker
  import baud_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             altExp,
  input logic [CFG_W-1:0] cfgQ,
  input logic             tickOut,
  input logic             sclStrobe
);
  logic unitPeriod;
  assign unitPeriod = altExp && (cfgQ == '0);

  AST_SCL_WITH_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sclStrobe |-> tickOut);                                   // R7
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (!tickOut && !sclStrobe));                     // R5
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut && !unitPeriod) |=> !tickOut);                    // R4
  AST_SCL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (sclStrobe && !unitPeriod) |=> !sclStrobe);                // R7
endmodule

bind i2c_baud_gen baud_checker chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .altExp(altExp),
  .cfgQ(cfgQ), .tickOut(tickOut), .sclStrobe(sclStrobe)
);

// File: tb/i2c_baud_gen_test.sv
module i2c_baud_gen_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn;
  logic [6:0] cfgWrData;
  logic       altExp;
  logic       tickOut;
  logic       sclStrobe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int curM = 0;
  int curN = 0;

  always #4 clk = ~clk;

  i2c_baud_gen uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .altExp(altExp), .tickOut(tickOut), .sclStrobe(sclStrobe)
  );

  function automatic int periodOf(int m, int n, bit alt);
    return (m + 1) * (1 << (alt ? n : n + 1));
  endfunction

  function automatic bit expTick(int c, int d);
    return (c > 0) && (c % d == 0);
  endfunction

  function automatic bit expScl(int c, int d);
    return (c > 0) && (c % (10 * d) == 0);
  endfunction

  // Compare both outputs, every cycle, against the formula for cycles
  // c = startC .. lastC counted from the restart edge. Sampling is at
  // the falling edge that follows edge c.
  task automatic watch(string tag, int d, int startC, int lastC);
    int tickBad = 0;
    int sclBad = 0;
    for (int c = startC; c <= lastC; c++) begin
      if (tickOut !== expTick(c, d)) begin
        if (tickBad == 0)
          $display("FAIL %s tickOut c=%0d got %0b exp %0b (period %0d)",
                   tag, c, tickOut, expTick(c, d), d);
        tickBad++;
      end
      if (sclStrobe !== expScl(c, d)) begin
        if (sclBad == 0)
          $display("FAIL R7 sclStrobe c=%0d got %0b exp %0b (period %0d)",
                   c, sclStrobe, expScl(c, d), d);
        sclBad++;
      end
      @(negedge clk);
    end
    checks += 2;
    if (tickBad != 0) failures++;
    if (sclBad != 0) failures++;
  endtask

  // doWrite=1: load M/N (R1, R5); doWrite=0: only change altExp (R6)
  task automatic run(bit doWrite, int m, int n, bit alt, string tag);
    int d;
    int len;
    @(negedge clk);
    if (doWrite) begin
      cfgWrEn   = 1'b1;
      cfgWrData = {m[3:0], n[2:0]};
      curM = m;
      curN = n;
    end
    altExp = alt;
    @(posedge clk);              // restart edge, c = 0
    @(negedge clk);
    cfgWrEn = 1'b0;
    d = periodOf(curM, curN, alt);
    len = 10 * d + 2 * d + 1;
    if (len > 50000) len = 10 * d + 1;
    watch(tag, d, 0, len);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0;
    cfgWrEn = 1'b0;
    cfgWrData = '0;
    altExp = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs held low while in reset
    checks++;
    if (tickOut !== 1'b0 || sclStrobe !== 1'b0) begin
      failures++;
      $display("FAIL R8 reset outputs got %0b%0b exp 00", tickOut, sclStrobe);
    end
    rstN = 1'b1;                 // next rising edge is c = 1
    @(negedge clk);
    // R8: cleared register gives period 2 in default mode
    watch("R8", 2, 1, 45);

    run(1, 0, 0, 1'b0, "R2");   // smallest default period, 2
    run(1, 0, 0, 1'b1, "R3");   // alt mode, tick every cycle
    run(1, 5, 2, 1'b1, "R3");
    run(1, 3, 1, 1'b0, "R2");
    run(0, 0, 0, 1'b1, "R6");   // mode toggle only, stored M/N kept
    run(0, 0, 0, 1'b0, "R6");
    run(1, 15, 0, 1'b0, "R1");  // M field top value
    run(1, 0, 7, 1'b1, "R1");   // N field top value
    run(1, 15, 7, 1'b0, "R2");  // largest ratio, 4096 cycles per tick

    // R5: a write in the middle of a count restarts it
    run(1, 2, 2, 1'b0, "R5");
    for (int i = 0; i < 12; i++) begin
      int m = $urandom_range(15, 0);
      int n = $urandom_range(3, 0);
      bit a = 1'($urandom_range(1, 0));
      run(1, m, n, a, a ? "R3" : "R2");
    end
    // R5: write partway through a long period
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = {4'd7, 3'd3}; curM = 7; curN = 3;
    @(negedge clk);
    cfgWrEn = 1'b0;
    repeat (37) @(negedge clk);
    run(1, 1, 1, 1'b0, "R5");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule